// File: doc/BRIEF.md
# Tile-Triggered Cartridge Bank Mapper

This block sits between an 8-bit console's two buses and the cartridge memories. On the processor side it decodes bank register writes and turns processor addresses into physical addresses for a small work RAM, one 16 KB program window that software can switch, and one 16 KB program window that always holds the last bank. On the picture side it turns pattern-table fetches into physical character ROM addresses. It also drives a nametable mirroring select.

The pattern area is split into a lower and an upper 4 KB half. Each half has two page registers and a one-bit latch that chooses between them. The latch is not written by the processor. It changes by itself when the picture unit fetches tile $FD or tile $FE of that half, so character banks can swap in the middle of a frame with no processor involvement. The ROM arrays, the RAM array and the nametable memory are outside the block. All address translation is combinational from registered state, so a read completes with the same latency as a plain ROM.

Top module: `tile_latch_mapper`

## Requirements
- R1: After a synchronous reset the program bank register, all four page registers and the mirroring select are 0, and both half latches are in the FE state (latch value 1).
- R2: A processor address in $6000-$7FFF asserts `wram_cs` with `wram_addr` = address − $6000, and `wram_we` follows `cpu_we` in that window only.
- R3: A processor address in $8000-$BFFF asserts `prg_rom_cs` with `prg_rom_addr` = bank × $4000 + address[13:0]. The bank is loaded from `cpu_wdata[3:0]` by a write in $A000-$AFFF and is used modulo `PRG_BANKS`.
- R4: A processor address in $C000-$FFFF asserts `prg_rom_cs` with `prg_rom_addr` = (`PRG_BANKS` − 1) × $4000 + address[13:0], whatever the bank register holds.
- R5: A write whose address bits 15:12 are $B, $C, $D or $E loads `cpu_wdata[4:0]` into, in that order: lower-half FD page, lower-half FE page, upper-half FD page, upper-half FE page.
- R6: A write in $F000-$FFFF sets `mirror_horiz` to `cpu_wdata[0]` (0 = vertical, 1 = horizontal), and the output holds that value until the next such write.
- R7: A picture read below $2000 asserts `chr_rom_cs` with `chr_rom_addr` = {page, address[11:0]}. The half is picked by address bit 12, and the page is that half's FE register when its latch is 1 and its FD register when its latch is 0.
- R8: A picture read with address bit 3 set and bits 11:4 equal to $FE sets the latch of the half given by bit 12 to FE. With bits 11:4 equal to $FD it clears that latch to FD. Every other read, and any read with bit 3 clear, leaves both latches unchanged.
- R9: The read that triggers a latch change returns the address from the page selected before the change. The new page applies from the next fetch.
- R10: Processor writes in $8000-$9FFF and picture-side writes (`ppu_we` high, `ppu_rd` low) change no register or latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_we | input | 1 | Processor write strobe |
| ppu_addr | input | 14 | Picture-unit address |
| ppu_rd | input | 1 | Picture-unit read strobe |
| ppu_we | input | 1 | Picture-unit write strobe (has no effect on state) |
| prg_rom_cs | output | 1 | Program ROM select |
| prg_rom_addr | output | PRG_AW | Program ROM physical address |
| wram_cs | output | 1 | Work RAM select |
| wram_we | output | 1 | Work RAM write enable |
| wram_addr | output | 13 | Work RAM address |
| chr_rom_cs | output | 1 | Character ROM select |
| chr_rom_addr | output | PAGE_W+12 | Character ROM physical address |
| mirror_horiz | output | 1 | Mirroring select, 1 = horizontal |

## Verification
Each page register is loaded with a distinct value whose upper data bits are junk. A sequence of fetches then shows which register feeds each half and whether the upper bits are masked. Trigger fetches at $xFD8 and $xFE8 are mixed with near misses: the same tile with bit 3 clear, a neighbouring tile ($FC), and a write strobe at a trigger address. This separates a correct latch rule from one that ignores bit 3, confuses the halves or reacts to writes. The address captured during a trigger fetch is compared with the one captured on the next fetch, which shows whether the update is applied late or early. The program bank is loaded with a value above the bank count to check the wrap, and the $8000-$9FFF writes show that they cannot disturb it.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
  typedef enum logic {
    LATCH_FD = 1'b0,
    LATCH_FE = 1'b1
  } latch_t;

  localparam logic [7:0] TILE_FD = 8'hFD;
  localparam logic [7:0] TILE_FE = 8'hFE;
  localparam logic [3:0] NIB_PRG_BANK = 4'hA;
  localparam logic [3:0] NIB_PAGE_BASE = 4'hB;
  localparam logic [3:0] NIB_MIRROR = 4'hF;
  localparam int NUM_PAGE_REGS = 4;
endpackage

// File: rtl/tlm_cpu_regs.sv
module tlm_cpu_regs
  import tlm_pkg::*;
#(
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_we,
  output logic [3:0]        prg_bank_q,
  output logic              mirror_q,
  output logic [NUM_PAGE_REGS-1:0] page_we,
  output logic [PAGE_W-1:0] page_wdata
);
  logic [3:0] nib;
  logic       unused_data;

  assign nib = cpu_addr[15:12];
  assign page_wdata = cpu_wdata[PAGE_W-1:0];
  assign unused_data = ^cpu_wdata[7:PAGE_W];

  for (genvar i = 0; i < NUM_PAGE_REGS; i++) begin : g_page_we
    assign page_we[i] = cpu_we && (nib == NIB_PAGE_BASE + 4'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_bank_q <= '0;
      mirror_q   <= 1'b0;
    end else if (cpu_we) begin
      if (nib == NIB_PRG_BANK) prg_bank_q <= cpu_wdata[3:0];
      if (nib == NIB_MIRROR)   mirror_q   <= cpu_wdata[0];
    end
  end

  AST_PRG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cpu_we && cpu_addr[15:12] == 4'hA) |=> $stable(prg_bank_q)); // R10
  AST_MIRROR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cpu_we && cpu_addr[15:12] == 4'hF) |=> $stable(mirror_q)); // R6
  AST_MIRROR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_addr[15:12] == 4'hF) |=> (mirror_q == $past(cpu_wdata[0]))); // R6
endmodule

// File: rtl/tlm_prg_map.sv
module tlm_prg_map #(
  parameter int PRG_BANKS = 8,
  localparam int PB_W   = $clog2(PRG_BANKS),
  localparam int PRG_AW = PB_W + 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_we,
  input  logic [3:0]        prg_bank_q,
  output logic              prg_rom_cs,
  output logic [PRG_AW-1:0] prg_rom_addr,
  output logic              wram_cs,
  output logic              wram_we,
  output logic [12:0]       wram_addr
);
  localparam logic [PB_W-1:0] LAST_BANK = PB_W'(PRG_BANKS - 1);

  logic [PB_W-1:0] sw_bank;
  logic [PB_W-1:0] sel_bank;

  always_comb begin
    sw_bank  = PB_W'(int'(prg_bank_q) % PRG_BANKS);
    sel_bank = cpu_addr[14] ? LAST_BANK : sw_bank;
  end

  assign prg_rom_cs   = cpu_addr[15];
  assign prg_rom_addr = {sel_bank, cpu_addr[13:0]};
  assign wram_cs      = (cpu_addr[15:13] == 3'b011);
  assign wram_we      = wram_cs && cpu_we;
  assign wram_addr    = cpu_addr[12:0];

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (rst)
    !(prg_rom_cs && wram_cs)); // R2
  AST_FIXED_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[15:14] == 2'b11) |-> (int'(prg_rom_addr[PRG_AW-1:14]) == PRG_BANKS - 1)); // R4
endmodule

// File: rtl/tlm_chr_unit.sv
module tlm_chr_unit
  import tlm_pkg::*;
#(
  parameter int PAGE_W = 5,
  localparam int CHR_AW = PAGE_W + 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_PAGE_REGS-1:0] page_we,
  input  logic [PAGE_W-1:0] page_wdata,
  input  logic [13:0]       ppu_addr,
  input  logic              ppu_rd,
  input  logic              ppu_we,
  output logic              chr_rom_cs,
  output logic [CHR_AW-1:0] chr_rom_addr
);
  logic [PAGE_W-1:0] page_fd_q [2];
  logic [PAGE_W-1:0] page_fe_q [2];
  latch_t            lat_q [2];
  logic [PAGE_W-1:0] half_page [2];
  logic              pat_rd;
  logic [7:0]        tile_row;

  assign pat_rd   = ppu_rd && !ppu_we && !ppu_addr[13];
  assign tile_row = ppu_addr[11:4];

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic hit;
    assign hit = pat_rd && ppu_addr[3] && (ppu_addr[12] == 1'(h));

    always_ff @(posedge clk) begin
      if (rst) begin
        page_fd_q[h] <= '0;
        page_fe_q[h] <= '0;
      end else begin
        if (page_we[2*h])   page_fd_q[h] <= page_wdata;
        if (page_we[2*h+1]) page_fe_q[h] <= page_wdata;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        lat_q[h] <= LATCH_FE;
      end else if (hit) begin
        if (tile_row == TILE_FE)      lat_q[h] <= LATCH_FE;
        else if (tile_row == TILE_FD) lat_q[h] <= LATCH_FD;
      end
    end

    assign half_page[h] = (lat_q[h] == LATCH_FE) ? page_fe_q[h] : page_fd_q[h];

    AST_LATCH_IDLE: assert property (@(posedge clk) disable iff (rst)
      !(ppu_rd && !ppu_we && !ppu_addr[13] && ppu_addr[12] == 1'(h)) |=> $stable(lat_q[h])); // R10
    AST_LATCH_TO_FE: assert property (@(posedge clk) disable iff (rst)
      (ppu_rd && !ppu_we && !ppu_addr[13] && ppu_addr[3] && ppu_addr[12] == 1'(h)
       && ppu_addr[11:4] == 8'hFE) |=> (lat_q[h] == LATCH_FE)); // R8
    AST_LATCH_TO_FD: assert property (@(posedge clk) disable iff (rst)
      (ppu_rd && !ppu_we && !ppu_addr[13] && ppu_addr[3] && ppu_addr[12] == 1'(h)
       && ppu_addr[11:4] == 8'hFD) |=> (lat_q[h] == LATCH_FD)); // R8
    AST_FD_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !page_we[2*h] |=> $stable(page_fd_q[h])); // R5
    AST_FE_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !page_we[2*h+1] |=> $stable(page_fe_q[h])); // R5
  end

  assign chr_rom_cs   = pat_rd;
  assign chr_rom_addr = {half_page[ppu_addr[12]], ppu_addr[11:0]};
endmodule

// File: rtl/tile_latch_mapper.sv
module tile_latch_mapper
  import tlm_pkg::*;
#(
  parameter int PRG_BANKS = 8,
  parameter int PAGE_W    = 5,
  localparam int PRG_AW = $clog2(PRG_BANKS) + 14,
  localparam int CHR_AW = PAGE_W + 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_we,
  input  logic [13:0]       ppu_addr,
  input  logic              ppu_rd,
  input  logic              ppu_we,
  output logic              prg_rom_cs,
  output logic [PRG_AW-1:0] prg_rom_addr,
  output logic              wram_cs,
  output logic              wram_we,
  output logic [12:0]       wram_addr,
  output logic              chr_rom_cs,
  output logic [CHR_AW-1:0] chr_rom_addr,
  output logic              mirror_horiz
);
  logic [3:0]               prg_bank_q;
  logic [NUM_PAGE_REGS-1:0] page_we;
  logic [PAGE_W-1:0]        page_wdata;

  tlm_cpu_regs #(.PAGE_W(PAGE_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_we     (cpu_we),
    .prg_bank_q (prg_bank_q),
    .mirror_q   (mirror_horiz),
    .page_we    (page_we),
    .page_wdata (page_wdata)
  );

  tlm_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .clk          (clk),
    .rst          (rst),
    .cpu_addr     (cpu_addr),
    .cpu_we       (cpu_we),
    .prg_bank_q   (prg_bank_q),
    .prg_rom_cs   (prg_rom_cs),
    .prg_rom_addr (prg_rom_addr),
    .wram_cs      (wram_cs),
    .wram_we      (wram_we),
    .wram_addr    (wram_addr)
  );

  tlm_chr_unit #(.PAGE_W(PAGE_W)) u_chr (
    .clk          (clk),
    .rst          (rst),
    .page_we      (page_we),
    .page_wdata   (page_wdata),
    .ppu_addr     (ppu_addr),
    .ppu_rd       (ppu_rd),
    .ppu_we       (ppu_we),
    .chr_rom_cs   (chr_rom_cs),
    .chr_rom_addr (chr_rom_addr)
  );
endmodule

// File: tb/tile_latch_mapper_tb.sv
module tile_latch_mapper_tb;
  localparam int PRG_BANKS = 8;
  localparam int PAGE_W = 5;
  localparam int PRG_AW = $clog2(PRG_BANKS) + 14;
  localparam int CHR_AW = PAGE_W + 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic        ppu_rd = 1'b0;
  logic        ppu_we = 1'b0;
  logic              prg_rom_cs, wram_cs, wram_we, chr_rom_cs, mirror_horiz;
  logic [PRG_AW-1:0] prg_rom_addr;
  logic [12:0]       wram_addr;
  logic [CHR_AW-1:0] chr_rom_addr;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tile_latch_mapper #(.PRG_BANKS(PRG_BANKS), .PAGE_W(PAGE_W)) u_dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
    .ppu_addr(ppu_addr), .ppu_rd(ppu_rd), .ppu_we(ppu_we),
    .prg_rom_cs(prg_rom_cs), .prg_rom_addr(prg_rom_addr), .wram_cs(wram_cs),
    .wram_we(wram_we), .wram_addr(wram_addr), .chr_rom_cs(chr_rom_cs),
    .chr_rom_addr(chr_rom_addr), .mirror_horiz(mirror_horiz)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic prg_expect(input logic [15:0] a, input longint exp, input string req);
    @(negedge clk);
    cpu_addr = a;
    #2;
    check(prg_rom_cs && prg_rom_addr == PRG_AW'(exp), req, prg_rom_addr, exp);
  endtask

  task automatic ppu_read(input logic [13:0] a, output logic [CHR_AW-1:0] got);
    @(negedge clk);
    ppu_addr = a; ppu_rd = 1'b1;
    #2;
    got = chr_rom_addr;
    @(negedge clk);
    ppu_rd = 1'b0;
  endtask

  function automatic logic [CHR_AW-1:0] chr_exp(input int page, input logic [13:0] a);
    return {PAGE_W'(page), a[11:0]};
  endfunction

  task automatic chr_expect(input logic [13:0] a, input int page, input string req);
    logic [CHR_AW-1:0] got;
    ppu_read(a, got);
    check(got == chr_exp(page, a), req, got, chr_exp(page, a));
  endtask

  task automatic t_reset;
    check(mirror_horiz == 1'b0, "R1 mirror", mirror_horiz, 0);
    prg_expect(16'h8123, 32'h0123, "R1 prg bank");
    chr_expect(14'h0010, 0, "R1 lower page");
    chr_expect(14'h1010, 0, "R1 upper page");
  endtask

  task automatic t_wram;
    @(negedge clk);
    cpu_addr = 16'h7ABC; cpu_we = 1'b1;
    #2;
    check(wram_cs && wram_we && !prg_rom_cs && wram_addr == 13'h1ABC, "R2 write",
          {wram_cs, wram_we, wram_addr}, {2'b11, 13'h1ABC});
    @(negedge clk);
    cpu_we = 1'b0; cpu_addr = 16'h6000;
    #2;
    check(wram_cs && !wram_we && wram_addr == 13'h0, "R2 read low edge", {wram_cs, wram_we}, 2'b10);
    cpu_addr = 16'h5FFF;
    #2;
    check(!wram_cs && !prg_rom_cs, "R2 outside", wram_cs, 0);
  endtask

  task automatic t_prg;
    cpu_write(16'hA000, 8'hF2);
    prg_expect(16'h8000, 2 * 32'h4000, "R3 bank 2");
    cpu_write(16'hAFFF, 8'h0B);
    prg_expect(16'hBFFF, 3 * 32'h4000 + 32'h3FFF, "R3 wrap 11 mod 8");
    prg_expect(16'hC000, 7 * 32'h4000, "R4 fixed start");
    prg_expect(16'hFFFF, 7 * 32'h4000 + 32'h3FFF, "R4 fixed end");
    cpu_write(16'h8000, 8'h01);
    cpu_write(16'h9FFF, 8'h05);
    prg_expect(16'h8456, 3 * 32'h4000 + 32'h0456, "R10 8000-9FFF ignored");
  endtask

  task automatic t_mirror;
    cpu_write(16'hF123, 8'h01);
    #2;
    check(mirror_horiz == 1'b1, "R6 horizontal", mirror_horiz, 1);
    cpu_write(16'hA000, 8'h03);
    #2;
    check(mirror_horiz == 1'b1, "R6 hold", mirror_horiz, 1);
    cpu_write(16'hFFFF, 8'hFE);
    #2;
    check(mirror_horiz == 1'b0, "R6 vertical", mirror_horiz, 0);
  endtask

  task automatic t_pages;
    logic [CHR_AW-1:0] got;
    cpu_write(16'hB000, 8'hE5);
    cpu_write(16'hC000, 8'h0A);
    cpu_write(16'hD000, 8'h71);
    cpu_write(16'hE000, 8'h1F);
    chr_expect(14'h0010, 8'h0A, "R1 R7 lower starts FE");
    chr_expect(14'h1ABC, 8'h1F, "R1 R7 upper starts FE");
    ppu_read(14'h0FD8, got);
    check(got == chr_exp(8'h0A, 14'h0FD8), "R9 trigger uses old page", got, chr_exp(8'h0A, 14'h0FD8));
    chr_expect(14'h0010, 8'h05, "R8 R9 lower now FD");
    chr_expect(14'h1010, 8'h1F, "R8 upper untouched");
    chr_expect(14'h0FE0, 8'h05, "R8 bit3 clear no change");
    chr_expect(14'h0FE7, 8'h05, "R8 bit3 clear again");
    chr_expect(14'h0FC8, 8'h05, "R8 other tile no change");
    ppu_read(14'h1FD8, got);
    check(got == chr_exp(8'h1F, 14'h1FD8), "R9 upper trigger old page", got, chr_exp(8'h1F, 14'h1FD8));
    chr_expect(14'h1000, 8'h11, "R5 R8 upper FD page");
    chr_expect(14'h0020, 8'h05, "R8 lower stays FD");
    chr_expect(14'h0FE8, 8'h05, "R9 lower FE trigger old page");
    chr_expect(14'h0FFF, 8'h0A, "R8 lower back to FE");
    chr_expect(14'h1FEF, 8'h11, "R9 upper FE trigger old page");
    chr_expect(14'h1333, 8'h1F, "R8 upper back to FE");
  endtask

  task automatic t_ppu_write;
    @(negedge clk);
    ppu_addr = 14'h0FD8; ppu_we = 1'b1; ppu_rd = 1'b0;
    #2;
    check(!chr_rom_cs, "R10 write no select", chr_rom_cs, 0);
    @(negedge clk);
    ppu_we = 1'b0;
    chr_expect(14'h0010, 8'h0A, "R10 ppu write ignored");
    @(negedge clk);
    ppu_addr = 14'h2FD8; ppu_rd = 1'b1;
    #2;
    check(!chr_rom_cs, "R7 above pattern area", chr_rom_cs, 0);
    @(negedge clk);
    ppu_rd = 1'b0;
    chr_expect(14'h0010, 8'h0A, "R8 nametable read no change");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_wram();
    t_prg();
    t_mirror();
    t_pages();
    t_ppu_write();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule